// File: doc/BRIEF.md
# UART Oversampling Baud Generator with Selectable Ratio

This block produces the timing strobes for a 16550-style serial port that has an extra speed-selection register. A 16-bit divisor sets how many core clocks make up one oversample tick. The speed mode sets how many ticks make up one bit: a fixed 16, a fixed 4, or a programmed count of 1 to 256. The transmitter gets one strobe per bit period. The receiver gets a strobe on one chosen tick inside each bit, which is where it samples the line.

Software reaches the block through a small byte-addressed register bus. Registers sit on 32-bit boundaries, so the byte address is the word offset times four. The divisor bytes share offsets 0 and 1 with the data path and are only visible while the divisor-access bit (bit 7 of the line-control register) is set.

The block has two counter chains that share one configuration. The transmit chain runs freely. The receive chain also restarts its phase on a start-bit falling edge, so the sample strobe lands at the chosen tick of each received bit.

Top module: `uart_os_baudgen`

## Requirements
- R1: Register map and reset values. Byte addresses: line control 0x0C (reset 0x00), speed mode 0x24 (bits 1:0, reset 0), sample count 0x28 (reset 0x00), sample point 0x2C (reset 0xFF), rate-fix control 0x34 (bit 0, reset 0). The divisor resets to 0x0001. Unused read bits and unmapped addresses read 0.
- R2: The divisor low byte (0x00) and high byte (0x04) are read and written only while line-control bit 7 is 1. While that bit is 0, these addresses read 0 and writes to them leave the divisor unchanged.
- R3: In speed modes 0 and 1, `os_tick` pulses once every D clocks and `tx_bit_tick` pulses once every 16·D clocks, where D is the effective divisor.
- R4: In speed mode 2, a bit lasts 4 ticks, so `tx_bit_tick` pulses once every 4·D clocks.
- R5: In speed mode 3, a bit lasts (sample count + 1) ticks, from 1 to 256.
- R6: `rx_sample` pulses on tick index k of each bit, counting from 0. k is 7 in modes 0 and 1, 1 in mode 2, and the sample-point value in mode 3. The pulse therefore comes D·(k+1) clocks after the bit starts.
- R7: A divisor value of 0 acts as 1, so a tick occurs every clock.
- R8: A write to either divisor byte (with access enabled), to the speed mode or to the sample count restarts both chains on that edge. The first tick then comes D clocks after the write edge, and the first bit strobe D·ticks-per-bit clocks after it. Writes to the sample point, the line control or the rate-fix register do not restart the chains.
- R9: While `rx_idle` is 1, a falling edge on `rx_line` restarts the receive chain, so `rx_sample` follows D·(k+1) clocks after the edge that sees the low level. While `rx_idle` is 0, such an edge has no effect.
- R10: The rate-fix register stores and returns bit 0 and has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from `bus_addr`) |
| rx_line | input | 1 | Serial receive line, already synchronized |
| rx_idle | input | 1 | Receiver waits for a start bit |
| os_tick | output | 1 | Oversample tick of the transmit chain |
| tx_bit_tick | output | 1 | One pulse per transmit bit period |
| rx_os_tick | output | 1 | Oversample tick of the receive chain |
| rx_sample | output | 1 | Receive sample strobe at the chosen tick |

## Verification
The hardest situation to reach from the ports is telling a chain that restarted apart from one that merely kept its phase. The stimulus makes a restarting write or a line fall several cycles after the last restart. It then checks that the next strobes are counted from the new edge and not from the old phase. The same kind of sequence shows that writes to the sample point and the rate-fix register, and a line fall while the receiver is busy, leave the phase alone. Random configurations cover divisor zero, all four modes and random sample points, and each is checked against cycle counts worked out from the requirements.

// File: rtl/uart_bg_pkg.sv
package uart_bg_pkg;

    localparam int DIV_W  = 16;
    localparam int REG_W  = 8;
    localparam int TICK_W = REG_W + 1;

    localparam int OFF_DLL  = 0;
    localparam int OFF_DLM  = 1;
    localparam int OFF_LCR  = 3;
    localparam int OFF_MODE = 9;
    localparam int OFF_SCNT = 10;
    localparam int OFF_SPNT = 11;
    localparam int OFF_RFIX = 13;

    localparam int DLAB_BIT = 7;

    localparam logic [REG_W-1:0] SCNT_RST = 8'h00;
    localparam logic [REG_W-1:0] SPNT_RST = 8'hFF;

    localparam int X16_TICKS = 16;
    localparam int X4_TICKS  = 4;

    typedef enum logic [1:0] {
        SPD_X16  = 2'd0,
        SPD_RSVD = 2'd1,
        SPD_X4   = 2'd2,
        SPD_PROG = 2'd3
    } speed_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [TICK_W-1:0] tpb;
        logic [TICK_W-1:0] smp_idx;
    } timing_cfg_t;

    function automatic timing_cfg_t derive_timing(
        input logic [DIV_W-1:0] dl,
        input speed_e           mode,
        input logic [REG_W-1:0] scnt,
        input logic [REG_W-1:0] spnt
    );
        timing_cfg_t r;
        r.div = (dl == '0) ? DIV_W'(1) : dl;
        case (mode)
            SPD_X4: begin
                r.tpb     = TICK_W'(X4_TICKS);
                r.smp_idx = TICK_W'((X4_TICKS - 2) / 2);
            end
            SPD_PROG: begin
                r.tpb     = {1'b0, scnt} + TICK_W'(1);
                r.smp_idx = {1'b0, spnt};
            end
            default: begin
                r.tpb     = TICK_W'(X16_TICKS);
                r.smp_idx = TICK_W'((X16_TICKS - 2) / 2);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uart_bg_regs.sv
module uart_bg_regs
    import uart_bg_pkg::*;
#(
    parameter int               ADDR_W  = 6,
    parameter logic [DIV_W-1:0] DIV_RST = 16'h0001
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output timing_cfg_t          cfg,
    output logic                 restart
);
    localparam int OFF_W = ADDR_W - 2;

    logic [REG_W-1:0] lcr_q;
    logic [DIV_W-1:0] dl_q;
    speed_e           mode_q;
    logic [REG_W-1:0] scnt_q;
    logic [REG_W-1:0] spnt_q;
    logic             rfix_q;

    logic             aligned;
    logic [OFF_W-1:0] off;
    logic             dlab;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign off     = bus_addr[ADDR_W-1:2];
    assign dlab    = lcr_q[DLAB_BIT];

    logic hit_dll, hit_dlm, hit_lcr, hit_mode, hit_scnt, hit_spnt, hit_rfix;
    assign hit_dll  = aligned && (off == OFF_W'(OFF_DLL));
    assign hit_dlm  = aligned && (off == OFF_W'(OFF_DLM));
    assign hit_lcr  = aligned && (off == OFF_W'(OFF_LCR));
    assign hit_mode = aligned && (off == OFF_W'(OFF_MODE));
    assign hit_scnt = aligned && (off == OFF_W'(OFF_SCNT));
    assign hit_spnt = aligned && (off == OFF_W'(OFF_SPNT));
    assign hit_rfix = aligned && (off == OFF_W'(OFF_RFIX));

    logic wr_dll, wr_dlm, wr_lcr, wr_mode, wr_scnt, wr_spnt, wr_rfix;
    assign wr_dll  = bus_wr && hit_dll && dlab;
    assign wr_dlm  = bus_wr && hit_dlm && dlab;
    assign wr_lcr  = bus_wr && hit_lcr;
    assign wr_mode = bus_wr && hit_mode;
    assign wr_scnt = bus_wr && hit_scnt;
    assign wr_spnt = bus_wr && hit_spnt;
    assign wr_rfix = bus_wr && hit_rfix;

    // Only writes that change the tick length or the bit length restart the chains
    assign restart = wr_dll || wr_dlm || wr_mode || wr_scnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q  <= '0;
            dl_q   <= DIV_RST;
            mode_q <= SPD_X16;
            scnt_q <= SCNT_RST;
            spnt_q <= SPNT_RST;
            rfix_q <= 1'b0;
        end else begin
            if (wr_lcr)  lcr_q                   <= bus_wdata;
            if (wr_dll)  dl_q[REG_W-1:0]         <= bus_wdata;
            if (wr_dlm)  dl_q[DIV_W-1:REG_W]     <= bus_wdata;
            if (wr_mode) mode_q                  <= speed_e'(bus_wdata[1:0]);
            if (wr_scnt) scnt_q                  <= bus_wdata;
            if (wr_spnt) spnt_q                  <= bus_wdata;
            if (wr_rfix) rfix_q                  <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_dll && dlab)  bus_rdata = dl_q[REG_W-1:0];
        if (hit_dlm && dlab)  bus_rdata = dl_q[DIV_W-1:REG_W];
        if (hit_lcr)          bus_rdata = lcr_q;
        if (hit_mode)         bus_rdata = {{(REG_W-2){1'b0}}, mode_q};
        if (hit_scnt)         bus_rdata = scnt_q;
        if (hit_spnt)         bus_rdata = spnt_q;
        if (hit_rfix)         bus_rdata = {{(REG_W-1){1'b0}}, rfix_q};
    end

    assign cfg = derive_timing(dl_q, mode_q, scnt_q, spnt_q);

    // R2: divisor untouched by writes at its offsets while access is off
    assert_dl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (hit_dll || hit_dlm) && !dlab) |=> $stable(dl_q));

    // R1: reset values present on the first cycle out of reset
    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (scnt_q == SCNT_RST && spnt_q == SPNT_RST &&
                        mode_q == SPD_X16 && dl_q == DIV_RST));

endmodule

// File: rtl/uart_bg_tick_chain.sv
module uart_bg_tick_chain
    import uart_bg_pkg::*;
#(
    parameter bit SAMPLE_EVT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  timing_cfg_t cfg,
    output logic        tick,
    output logic        evt
);
    logic [DIV_W-1:0]  pre_q;
    logic [TICK_W-1:0] tk_q;
    logic              last_tick;

    assign tick      = (pre_q == cfg.div - DIV_W'(1));
    assign last_tick = (tk_q == cfg.tpb - TICK_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
            tk_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            tk_q  <= last_tick ? '0 : tk_q + TICK_W'(1);
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end

    generate
        if (SAMPLE_EVT) begin : g_sample
            assign evt = tick && (tk_q == cfg.smp_idx);
        end else begin : g_bitend
            assign evt = tick && last_tick;
        end
    endgenerate

    // R7: prescaler stays inside the effective divisor
    assert_pre_bound_R7: assert property (@(posedge clk) disable iff (rst)
        pre_q < cfg.div);

    // R5: tick index stays inside the bit length
    assert_tick_bound_R5: assert property (@(posedge clk) disable iff (rst)
        tk_q < cfg.tpb);

    // R6: strobes only ever land on a tick
    assert_evt_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        evt |-> tick);

    // R8: after a restart the chain is at the start of a tick
    assert_restart_phase_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (tick == (cfg.div == DIV_W'(1))));

endmodule

// File: rtl/uart_os_baudgen.sv
module uart_os_baudgen
    import uart_bg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_line,
    input  logic              rx_idle,
    output logic              os_tick,
    output logic              tx_bit_tick,
    output logic              rx_os_tick,
    output logic              rx_sample
);
    localparam int N_CHAIN = 2;

    timing_cfg_t        cfg;
    logic               restart;
    logic               rx_prev_q;
    logic               start_fall;
    logic [N_CHAIN-1:0] clr_v;
    logic [N_CHAIN-1:0] tick_v;
    logic [N_CHAIN-1:0] evt_v;

    uart_bg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .restart   (restart)
    );

    always_ff @(posedge clk) begin
        if (rst) rx_prev_q <= 1'b1;
        else     rx_prev_q <= rx_line;
    end

    assign start_fall = rx_idle && rx_prev_q && !rx_line;

    assign clr_v[0] = restart;
    assign clr_v[1] = restart || start_fall;

    generate
        for (genvar g = 0; g < N_CHAIN; g++) begin : g_chain
            uart_bg_tick_chain #(.SAMPLE_EVT(g == 1)) u_chain (
                .clk   (clk),
                .rst   (rst),
                .clear (clr_v[g]),
                .cfg   (cfg),
                .tick  (tick_v[g]),
                .evt   (evt_v[g])
            );
        end
    endgenerate

    assign os_tick     = tick_v[0];
    assign tx_bit_tick = evt_v[0];
    assign rx_os_tick  = tick_v[1];
    assign rx_sample   = evt_v[1];

    // R8: a configuration restart aligns both chains
    assert_chains_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (os_tick == rx_os_tick));

endmodule

// File: tb/uart_os_baudgen_tb_top.sv
module uart_os_baudgen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_line = 1'b1;
    logic       rx_idle = 1'b0;
    logic       os_tick, tx_bit_tick, rx_os_tick, rx_sample;

    int checks = 0;
    int fails  = 0;

    localparam logic [5:0] A_DLL = 6'h00, A_DLM = 6'h04, A_LCR = 6'h0C,
                           A_MODE = 6'h24, A_SC = 6'h28, A_SP = 6'h2C, A_RF = 6'h34;

    always #2 clk = ~clk;

    uart_os_baudgen dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_line(rx_line),
        .rx_idle(rx_idle), .os_tick(os_tick), .tx_bit_tick(tx_bit_tick),
        .rx_os_tick(rx_os_tick), .rx_sample(rx_sample)
    );

    function automatic int exp_tpb(int mode, int sc);
        if (mode == 2) return 4;
        if (mode == 3) return sc + 1;
        return 16;
    endfunction

    function automatic int exp_idx(int mode, int sp);
        if (mode == 2) return 1;
        if (mode == 3) return sp;
        return 7;
    endfunction

    function automatic int eff_div(int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [5:0] a, input int exp, input string req);
        bus_addr = a;
        #1;
        check(int'(bus_rdata), exp, req);
    endtask

    // Writes the full configuration; sample count last so its edge is the restart reference
    task automatic configure(input int d, input int mode, input int sc, input int sp);
        bwrite(A_LCR, 8'h80);
        bwrite(A_DLL, 8'(d));
        bwrite(A_DLM, 8'(d >> 8));
        bwrite(A_LCR, 8'h03);
        bwrite(A_MODE, 8'(mode));
        bwrite(A_SP, 8'(sp));
        bwrite(A_SC, 8'(sc));
    endtask

    // Counts negedges from the reference edge (n0 = current position) to first pulses
    task automatic measure(input int n0, input int limit,
                           output int n_os, output int n_bit, output int n_smp);
        int n = n0;
        n_os = -1; n_bit = -1; n_smp = -1;
        while (n <= limit) begin
            if (os_tick     && n_os  < 0) n_os  = n;
            if (tx_bit_tick && n_bit < 0) n_bit = n;
            if (rx_sample   && n_smp < 0) n_smp = n;
            if (n_os >= 0 && n_bit >= 0 && n_smp >= 0) break;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_cfg(input int d, input int mode, input int sc, input int sp,
                           input string req);
        int a, b, s, de;
        de = eff_div(d);
        configure(d, mode, sc, sp);
        measure(1, de * 260 + 4, a, b, s);
        check(a, de, {req, " first tick"});
        check(b, de * exp_tpb(mode, sc), {req, " first bit tick"});
        check(s, de * (exp_idx(mode, sp) + 1), {req, " first sample"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int a, b, s;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        bread(A_LCR, 8'h00, "R1 lcr");
        bread(A_MODE, 0, "R1 mode");
        bread(A_SC, 8'h00, "R1 sample count");
        bread(A_SP, 8'hFF, "R1 sample point");
        bread(A_RF, 0, "R1 rate fix");
        bread(6'h3C, 0, "R1 unmapped");
        bwrite(A_LCR, 8'h80);
        bread(A_DLL, 1, "R1 divisor low");
        bread(A_DLM, 0, "R1 divisor high");

        // R2 divisor hidden while access bit clear
        bwrite(A_LCR, 8'h03);
        bread(A_LCR, 8'h03, "R1 lcr readback");
        bwrite(A_DLL, 8'h55);
        bwrite(A_DLM, 8'h66);
        bread(A_DLL, 0, "R2 hidden read");
        bwrite(A_LCR, 8'h83);
        bread(A_DLL, 1, "R2 low unchanged");
        bread(A_DLM, 0, "R2 high unchanged");
        bwrite(A_LCR, 8'h03);

        // R10 rate-fix register
        bwrite(A_RF, 8'h01);
        bread(A_RF, 1, "R10 set");
        bwrite(A_RF, 8'h00);
        bread(A_RF, 0, "R10 cleared");

        // Directed modes
        run_cfg(3, 0, 0, 8'hFF, "R3 R6 mode0");
        run_cfg(2, 1, 0, 8'hFF, "R3 R6 mode1");
        run_cfg(5, 2, 0, 8'hFF, "R4 R6 mode2");
        run_cfg(2, 3, 9, 4, "R5 R6 mode3");
        run_cfg(1, 3, 255, 127, "R5 mode3 max");
        run_cfg(1, 3, 0, 0, "R5 mode3 one tick");
        run_cfg(0, 2, 0, 8'hFF, "R7 zero divisor");

        // R8 and R10: sample-point and rate-fix writes do not restart
        configure(3, 0, 0, 8'hFF);
        bwrite(A_SP, 8'h07);
        bwrite(A_RF, 8'h01);
        measure(3, 200, a, b, s);
        check(a, 3, "R8 R10 tick phase kept");
        check(b, 48, "R8 R10 bit phase kept");
        bwrite(A_RF, 8'h00);

        // R8 mode write restarts mid-bit
        configure(3, 0, 0, 8'hFF);
        repeat (9) @(negedge clk);
        bwrite(A_MODE, 8'h00);
        measure(1, 200, a, b, s);
        check(b, 48, "R8 mode write restart");
        check(s, 24, "R8 restart sample");

        // R8 divisor write restarts mid-bit (LCR write itself does not)
        configure(3, 0, 0, 8'hFF);
        repeat (5) @(negedge clk);
        bwrite(A_LCR, 8'h80);
        bwrite(A_DLM, 8'h00);
        measure(1, 200, a, b, s);
        check(b, 48, "R8 divisor write restart");
        bwrite(A_LCR, 8'h03);

        // R9 start-bit resync while idle
        configure(2, 0, 0, 8'hFF);
        rx_idle = 1'b1;
        repeat (3) @(negedge clk);
        rx_line = 1'b0;
        measure(4, 200, a, b, s);
        check(s, 4 + 2 * 8, "R9 idle fall resync");
        check(b, 32, "R9 tx chain untouched");
        rx_line = 1'b1;
        rx_idle = 1'b0;

        // R9 fall ignored while busy
        configure(2, 0, 0, 8'hFF);
        repeat (3) @(negedge clk);
        rx_line = 1'b0;
        measure(4, 200, a, b, s);
        check(s, 16, "R9 busy fall ignored");
        rx_line = 1'b1;

        // Random configurations
        for (int i = 0; i < 14; i++) begin
            int d, mode, sc, sp;
            d    = $urandom_range(0, 6);
            mode = $urandom_range(0, 3);
            sc   = (i % 5 == 4) ? 255 : $urandom_range(0, 20);
            sp   = (mode == 3) ? $urandom_range(0, sc) : $urandom_range(0, 255);
            run_cfg(d, mode, sc, sp, "R3 R4 R5 R6 R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule